// File: doc/BRIEF.md
# IP Header Exception Classifier

The block watches a byte stream whose first marked byte is the first byte of an IPv4 or IPv6 header. Together with that first byte it takes the whole frame's byte count, the number of link-layer bytes in front of the IP header, and two upstream conditions: a receive error and a "this frame is not IP" indication. As header bytes go by it captures the fields it needs and keeps a running ones-complement sum of the header. It then produces a small set of decode flags: IPv6, fragment, TCP-or-UDP payload, encrypted (ESP or AH) payload and compressed payload. It also produces an exception flag with a numeric cause.

The decision is registered and presented for exactly one cycle, the cycle after the last header byte the block needs. For IPv4 that byte is given by the header-length nibble, and for IPv6 by the fixed 40-byte header. When the frame ends earlier, the last byte that exists in the frame is used instead. A source may pause the stream with idle cycles. Any bytes it sends after that point, until the next start byte, are ignored. A start byte always begins a new header, so packets may follow one another with no gap.

Top module: `ip_hdr_classifier`

## Requirements
- R1: When the version nibble (byte 0, bits 7:4) is neither 4 nor 6, ip_exc is 1 and exc_code is 1. All decode flags are 0, and the result appears after byte 0 alone.
- R2: For IPv4 whose whole header fits in the frame, the 16-bit ones-complement sum of all header words (byte 2k is the high byte) must be 0xFFFF; otherwise exc_code is 2.
- R3: exc_code is 3 when the IP bytes available (frame_len minus l2_len, floored at 0) are fewer than the header needs. That need is 4 times the header-length nibble (byte 0, bits 3:0) for IPv4, or 40 for IPv6. An IPv4 header-length nibble below 5 also gives code 3.
- R4: exc_code is 4 when the available bytes are fewer than the datagram length. That length is the IPv4 total length (bytes 2..3) or 40 plus the IPv6 payload length (bytes 4..5). Available bytes beyond it (pad) raise nothing.
- R5: exc_code is 5 when the IPv4 TTL (byte 8) or the IPv6 hop limit (byte 7) is zero.
- R6: exc_code is 6 when an IPv4 header-length nibble is greater than 5.
- R7: When several causes apply, the lowest-numbered code is reported; ip_exc is 1 exactly when exc_code is nonzero.
- R8: With a complete header, is_l4tu is set for protocol 6 or 17 and is_ipsec for 50 or 51. is_comp is set for 108, and at most one of these three is set. The protocol is byte 9 for IPv4 and byte 6 (next header) for IPv6, and is_v6 is set for version 6.
- R9: is_frag is set for IPv4 when the more-fragments bit (byte 6, bit 5) is 1 or the 13-bit offset (byte 6 bits 4:0, byte 7) is nonzero. It is set for IPv6 when the next header is 44. The don't-fragment bit alone does not set it.
- R10: When rcv_err or not_ip is 1 with the start byte, every flag, ip_exc and exc_code are 0, and the result appears after byte 0.
- R11: out_valid is 1 for one cycle, the cycle after the block's last byte. That byte is number min(need, available) counted from 1, and at least the first byte, where need is the R3 header size (20 when the nibble is below 5, and 1 under R1 or R10). Idle cycles may fall between bytes, and bytes after the last one are ignored until the next start byte.
- R12: After reset out_valid, ip_exc and exc_code are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A header byte is present on in_data |
| in_sop | input | 1 | This byte is byte 0 of a new IP header (sampled with in_valid) |
| in_data | input | 8 | Header byte |
| frame_len | input | LEN_W (16) | Total frame bytes, sampled with the start byte |
| l2_len | input | L2_W (8) | Link-layer bytes ahead of the IP header, sampled with the start byte |
| rcv_err | input | 1 | Receive error on this frame, sampled with the start byte |
| not_ip | input | 1 | Frame not recognised as IP, sampled with the start byte |
| out_valid | output | 1 | One-cycle strobe: result fields are valid |
| is_v6 | output | 1 | IPv6 header |
| is_frag | output | 1 | Fragment |
| is_l4tu | output | 1 | TCP or UDP payload |
| is_ipsec | output | 1 | ESP or AH payload |
| is_comp | output | 1 | Compressed payload |
| ip_exc | output | 1 | An IP exception was found |
| exc_code | output | CODE_W (8) | Exception cause, 0 when none |

## Verification
The hardest cases to reach from the ports are the truncated headers. There the end byte is set by the frame count, not by the header. The result must then come out after a byte inside the header, while stale captured fields from the last packet are still held. The stimulus sends a full-length header behind a short frame_len, so the bytes after the end byte are present on the bus and must be ignored. It also runs packets back to back and with idle gaps. Overlapping causes get their own stimuli (zero TTL with a bad sum, options with a short length) to test the priority order.

// File: rtl/ipc_pkg.sv
package ipc_pkg;

  localparam logic [7:0] PROTO_TCP     = 8'd6;
  localparam logic [7:0] PROTO_UDP     = 8'd17;
  localparam logic [7:0] PROTO_ESP     = 8'd50;
  localparam logic [7:0] PROTO_AH      = 8'd51;
  localparam logic [7:0] PROTO_COMP    = 8'd108;
  localparam logic [7:0] PROTO_V6_FRAG = 8'd44;

  typedef enum logic [7:0] {
    EXC_NONE      = 8'd0,
    EXC_VERSION   = 8'd1,
    EXC_CSUM      = 8'd2,
    EXC_HDR_SHORT = 8'd3,
    EXC_LEN_SHORT = 8'd4,
    EXC_HOP_ZERO  = 8'd5,
    EXC_OPTIONS   = 8'd6
  } exc_code_e;

  typedef struct packed {
    logic v6;
    logic frag;
    logic l4tu;
    logic ipsec;
    logic comp;
  } ipc_flags_t;

endpackage

// File: rtl/ipc_byte_track.sv
module ipc_byte_track #(
  parameter int LEN_W        = 16,
  parameter int IDX_W        = 6,
  parameter int V6_HDR_BYTES = 40
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic             in_sop,
  input  logic [7:0]       in_data,
  input  logic [LEN_W-1:0] avail_cur,
  input  logic             supp_cur,
  output logic             take,
  output logic [IDX_W-1:0] idx_cur,
  output logic             last
);

  logic             busy_r;
  logic [IDX_W-1:0] idx_r;
  logic [IDX_W-1:0] stop_r;
  logic [IDX_W-1:0] need0;
  logic [IDX_W-1:0] stop0;
  logic [IDX_W-1:0] stop_cur;
  logic [3:0]       ver0;
  logic [3:0]       ihl0;

  assign ver0 = in_data[7:4];
  assign ihl0 = in_data[3:0];

  // bytes needed, judged from byte 0
  always_comb begin
    if (supp_cur) begin
      need0 = IDX_W'(1);
    end else if (ver0 == 4'd4) begin
      need0 = (ihl0 < 4'd5) ? IDX_W'(20) : IDX_W'({ihl0, 2'b00});
    end else if (ver0 == 4'd6) begin
      need0 = IDX_W'(V6_HDR_BYTES);
    end else begin
      need0 = IDX_W'(1);
    end
  end

  always_comb begin
    if (avail_cur < LEN_W'(need0)) begin
      stop0 = IDX_W'(avail_cur);
    end else begin
      stop0 = need0;
    end
    if (stop0 == '0) begin
      stop0 = IDX_W'(1);
    end
  end

  assign take     = in_valid && (in_sop || busy_r);
  assign idx_cur  = in_sop ? '0 : idx_r;
  assign stop_cur = in_sop ? stop0 : stop_r;
  assign last     = take && (idx_cur == stop_cur - IDX_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_r <= 1'b0;
      idx_r  <= '0;
      stop_r <= '0;
    end else if (take) begin
      idx_r  <= idx_cur + IDX_W'(1);
      busy_r <= !last;
      if (in_sop) begin
        stop_r <= stop0;
      end
    end
  end

  // R11
  idx_below_stop_chk: assert property (@(posedge clk) disable iff (rst)
    busy_r |-> (idx_r < stop_r));

  // R11
  stop_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    busy_r |-> (stop_r != '0));

endmodule

// File: rtl/ipc_hdr_capture.sv
module ipc_hdr_capture #(
  parameter int CAP_BYTES = 10,
  parameter int IDX_W     = 6
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      take,
  input  logic [IDX_W-1:0]          idx_cur,
  input  logic [7:0]                in_data,
  output logic [CAP_BYTES-1:0][7:0] hdr_n
);

  for (genvar k = 0; k < CAP_BYTES; k++) begin : g_byte
    logic       hit;
    logic [7:0] hdr_r;

    assign hit = take && (idx_cur == IDX_W'(k));

    always_ff @(posedge clk) begin
      if (rst) begin
        hdr_r <= '0;
      end else if (hit) begin
        hdr_r <= in_data;
      end
    end

    // look-through: the byte on the bus is visible in its own cycle
    assign hdr_n[k] = hit ? in_data : hdr_r;
  end

endmodule

// File: rtl/ipc_csum16.sv
module ipc_csum16 #(
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             take,
  input  logic             in_sop,
  input  logic [IDX_W-1:0] idx_cur,
  input  logic [7:0]       in_data,
  output logic [15:0]      sum_n
);

  logic [15:0] acc_r;
  logic [7:0]  hi_r;
  logic [15:0] base;
  logic [16:0] raw;
  logic [15:0] folded;

  assign base   = in_sop ? 16'h0000 : acc_r;
  assign raw    = {1'b0, base} + {1'b0, hi_r, in_data};
  assign folded = raw[15:0] + {15'd0, raw[16]};
  assign sum_n  = (take && idx_cur[0]) ? folded : base;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_r <= '0;
      hi_r  <= '0;
    end else if (take) begin
      acc_r <= sum_n;
      if (!idx_cur[0]) begin
        hi_r <= in_data;
      end
    end
  end

endmodule

// File: rtl/ip_hdr_classifier.sv
module ip_hdr_classifier
  import ipc_pkg::*;
#(
  parameter int LEN_W         = 16,
  parameter int L2_W          = 8,
  parameter int CODE_W        = 8,
  parameter int MAX_HDR_BYTES = 60,
  parameter int V6_HDR_BYTES  = 40,
  parameter int CAP_BYTES     = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              in_sop,
  input  logic [7:0]        in_data,
  input  logic [LEN_W-1:0]  frame_len,
  input  logic [L2_W-1:0]   l2_len,
  input  logic              rcv_err,
  input  logic              not_ip,
  output logic              out_valid,
  output logic              is_v6,
  output logic              is_frag,
  output logic              is_l4tu,
  output logic              is_ipsec,
  output logic              is_comp,
  output logic              ip_exc,
  output logic [CODE_W-1:0] exc_code
);

  localparam int IDX_W = $clog2(MAX_HDR_BYTES + 1);

  logic                      take;
  logic [IDX_W-1:0]          idx_cur;
  logic                      last;
  logic [CAP_BYTES-1:0][7:0] hdr_n;
  logic [15:0]               sum_n;

  logic [LEN_W-1:0] avail_in;
  logic [LEN_W-1:0] avail_r;
  logic [LEN_W-1:0] avail_cur;
  logic             supp_r;
  logic             supp_cur;

  assign avail_in  = (frame_len > LEN_W'(l2_len)) ? (frame_len - LEN_W'(l2_len)) : '0;
  assign avail_cur = in_sop ? avail_in : avail_r;
  assign supp_cur  = in_sop ? (rcv_err || not_ip) : supp_r;

  always_ff @(posedge clk) begin
    if (rst) begin
      avail_r <= '0;
      supp_r  <= 1'b0;
    end else if (in_valid && in_sop) begin
      avail_r <= avail_in;
      supp_r  <= rcv_err || not_ip;
    end
  end

  ipc_byte_track #(
    .LEN_W       (LEN_W),
    .IDX_W       (IDX_W),
    .V6_HDR_BYTES(V6_HDR_BYTES)
  ) i_track (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_sop   (in_sop),
    .in_data  (in_data),
    .avail_cur(avail_cur),
    .supp_cur (supp_cur),
    .take     (take),
    .idx_cur  (idx_cur),
    .last     (last)
  );

  ipc_hdr_capture #(
    .CAP_BYTES(CAP_BYTES),
    .IDX_W    (IDX_W)
  ) i_cap (
    .clk    (clk),
    .rst    (rst),
    .take   (take),
    .idx_cur(idx_cur),
    .in_data(in_data),
    .hdr_n  (hdr_n)
  );

  ipc_csum16 #(
    .IDX_W(IDX_W)
  ) i_csum (
    .clk    (clk),
    .rst    (rst),
    .take   (take),
    .in_sop (in_sop),
    .idx_cur(idx_cur),
    .in_data(in_data),
    .sum_n  (sum_n)
  );

  // decision from the look-through header view
  logic [3:0]     ver;
  logic [3:0]     ihl;
  logic           v4;
  logic           v6;
  logic           v4_done;
  logic           v6_done;
  logic           done;
  logic [LEN_W:0] need_len;
  logic [7:0]     proto;
  logic           c_ver, c_csum, c_short, c_len, c_hop, c_opt;
  logic           exc_any;
  exc_code_e      code_c;
  ipc_flags_t     flags_c;

  assign ver     = hdr_n[0][7:4];
  assign ihl     = hdr_n[0][3:0];
  assign v4      = (ver == 4'd4);
  assign v6      = (ver == 4'd6);
  assign v4_done = (ihl >= 4'd5) && (avail_cur >= LEN_W'({ihl, 2'b00}));
  assign v6_done = (avail_cur >= LEN_W'(V6_HDR_BYTES));
  assign done    = v4 ? v4_done : (v6 && v6_done);
  assign proto   = v4 ? hdr_n[9] : hdr_n[6];

  always_comb begin
    if (v4) begin
      need_len = {1'b0, hdr_n[2], hdr_n[3]};
    end else begin
      need_len = {1'b0, hdr_n[4], hdr_n[5]} + (LEN_W+1)'(V6_HDR_BYTES);
    end
  end

  always_comb begin
    c_ver   = !supp_cur && !(v4 || v6);
    c_csum  = !supp_cur && v4 && v4_done && (sum_n != 16'hFFFF);
    c_short = !supp_cur && ((v4 && !v4_done) || (v6 && !v6_done));
    c_len   = !supp_cur && done && (need_len > {1'b0, avail_cur});
    c_hop   = !supp_cur && done && (v4 ? (hdr_n[8] == 8'd0) : (hdr_n[7] == 8'd0));
    c_opt   = !supp_cur && v4 && (ihl > 4'd5);
    exc_any = c_ver || c_csum || c_short || c_len || c_hop || c_opt;
  end

  always_comb begin
    if (c_ver)        code_c = EXC_VERSION;
    else if (c_csum)  code_c = EXC_CSUM;
    else if (c_short) code_c = EXC_HDR_SHORT;
    else if (c_len)   code_c = EXC_LEN_SHORT;
    else if (c_hop)   code_c = EXC_HOP_ZERO;
    else if (c_opt)   code_c = EXC_OPTIONS;
    else              code_c = EXC_NONE;
  end

  always_comb begin
    flags_c       = '0;
    flags_c.v6    = !supp_cur && v6;
    if (!supp_cur && done) begin
      flags_c.l4tu  = (proto == PROTO_TCP) || (proto == PROTO_UDP);
      flags_c.ipsec = (proto == PROTO_ESP) || (proto == PROTO_AH);
      flags_c.comp  = (proto == PROTO_COMP);
      if (v4) begin
        flags_c.frag = hdr_n[6][5] || ({hdr_n[6][4:0], hdr_n[7]} != 13'd0);
      end else begin
        flags_c.frag = (proto == PROTO_V6_FRAG);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      is_v6     <= 1'b0;
      is_frag   <= 1'b0;
      is_l4tu   <= 1'b0;
      is_ipsec  <= 1'b0;
      is_comp   <= 1'b0;
      ip_exc    <= 1'b0;
      exc_code  <= '0;
    end else begin
      out_valid <= last;
      if (last) begin
        is_v6    <= flags_c.v6;
        is_frag  <= flags_c.frag;
        is_l4tu  <= flags_c.l4tu;
        is_ipsec <= flags_c.ipsec;
        is_comp  <= flags_c.comp;
        ip_exc   <= exc_any;
        exc_code <= CODE_W'(code_c);
      end
    end
  end

  // R7
  code_range_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (exc_code <= CODE_W'(EXC_OPTIONS)));

  // R7
  exc_agree_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (ip_exc == (exc_code != '0)));

  // R8
  one_class_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $onehot0({is_l4tu, is_ipsec, is_comp}));

  // R11
  out_after_byte_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid));

  // R1
  version_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && (exc_code == CODE_W'(EXC_VERSION))) |-> !(is_v6 || is_frag || is_l4tu));

endmodule

// File: tb/test_ip_hdr_classifier.sv
`timescale 1ns/1ps
module test_ip_hdr_classifier;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_sop = 1'b0;
  logic [7:0]  in_data = 8'd0;
  logic [15:0] frame_len = 16'd0;
  logic [7:0]  l2_len = 8'd0;
  logic        rcv_err = 1'b0;
  logic        not_ip = 1'b0;
  logic        out_valid, is_v6, is_frag, is_l4tu, is_ipsec, is_comp, ip_exc;
  logic [7:0]  exc_code;

  ip_hdr_classifier i_ip_hdr_classifier (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sop(in_sop), .in_data(in_data),
    .frame_len(frame_len), .l2_len(l2_len), .rcv_err(rcv_err), .not_ip(not_ip),
    .out_valid(out_valid), .is_v6(is_v6), .is_frag(is_frag), .is_l4tu(is_l4tu),
    .is_ipsec(is_ipsec), .is_comp(is_comp), .ip_exc(ip_exc), .exc_code(exc_code)
  );

  always #4 clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  logic [7:0] pkt [0:63];

  // model results
  int e_stop, e_code;
  bit e_v6, e_frag, e_l4, e_sec, e_comp;
  // snapshot awaiting comparison
  bit arm = 0;
  bit mon_on = 0;
  int a_code;
  bit a_v6, a_frag, a_l4, a_sec, a_comp;
  string a_tag;

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  function automatic int hsum(int nbytes);
    int s = 0;
    for (int i = 0; i + 1 < nbytes; i += 2) begin
      s = s + ((int'(pkt[i]) << 8) | int'(pkt[i+1]));
      s = (s & 16'hFFFF) + (s >> 16);
    end
    return s;
  endfunction

  task automatic model(int flen, int l2, bit rcv, bit nip);
    int avail, ver, ihl, need, tot, proto, ttl;
    bit done, csok;
    avail = (flen > l2) ? flen - l2 : 0;
    e_stop = 1; e_code = 0;
    e_v6 = 0; e_frag = 0; e_l4 = 0; e_sec = 0; e_comp = 0;
    if (rcv || nip) return;
    ver = int'(pkt[0][7:4]);
    ihl = int'(pkt[0][3:0]);
    if (ver == 4) begin
      need = (ihl < 5) ? 20 : ihl * 4;
      done = (ihl >= 5) && (avail >= ihl * 4);
      tot = (int'(pkt[2]) << 8) | int'(pkt[3]);
      proto = int'(pkt[9]);
      ttl = int'(pkt[8]);
      csok = (hsum(ihl * 4) == 16'hFFFF);
    end else if (ver == 6) begin
      need = 40;
      done = (avail >= 40);
      tot = ((int'(pkt[4]) << 8) | int'(pkt[5])) + 40;
      proto = int'(pkt[6]);
      ttl = int'(pkt[7]);
      csok = 1;
    end else begin
      e_code = 1;
      return;
    end
    e_stop = (avail < need) ? avail : need;
    if (e_stop == 0) e_stop = 1;
    e_v6 = (ver == 6);
    if (ver == 4 && done && !csok) e_code = 2;
    else if (!done) e_code = 3;
    else if (tot > avail) e_code = 4;
    else if (ttl == 0) e_code = 5;
    else if (ver == 4 && ihl > 5) e_code = 6;
    if (done) begin
      e_l4 = (proto == 6) || (proto == 17);
      e_sec = (proto == 50) || (proto == 51);
      e_comp = (proto == 108);
      if (ver == 4) e_frag = pkt[6][5] || ({pkt[6][4:0], pkt[7]} != 13'd0);
      else e_frag = (proto == 44);
    end
  endtask

  task automatic fill();
    for (int i = 0; i < 64; i++) pkt[i] = 8'(i * 7 + 3);
  endtask

  task automatic mk_v4(int ihl, int tot, int ttl, int proto, int frag16, bit good);
    int cs;
    fill();
    pkt[0] = {4'd4, 4'(ihl)};
    pkt[1] = 8'h00;
    pkt[2] = 8'(tot >> 8);
    pkt[3] = 8'(tot);
    pkt[6] = 8'(frag16 >> 8);
    pkt[7] = 8'(frag16);
    pkt[8] = 8'(ttl);
    pkt[9] = 8'(proto);
    pkt[10] = 8'h00;
    pkt[11] = 8'h00;
    if (ihl >= 5) begin
      cs = (~hsum(ihl * 4)) & 16'hFFFF;
      pkt[10] = 8'(cs >> 8);
      pkt[11] = 8'(cs);
      if (!good) pkt[11] = pkt[11] ^ 8'h01;
    end
  endtask

  task automatic mk_v6(int pl, int nh, int hop);
    fill();
    pkt[0] = 8'h60;
    pkt[4] = 8'(pl >> 8);
    pkt[5] = 8'(pl);
    pkt[6] = 8'(nh);
    pkt[7] = 8'(hop);
  endtask

  task automatic send(int nbytes, int flen, int l2, bit rcv, bit nip, bit gaps, string tag);
    model(flen, l2, rcv, nip);
    for (int i = 0; i < nbytes; i++) begin
      if (gaps && (i % 3 == 1)) begin
        @(posedge clk); #2;
        in_valid = 1'b0; in_sop = 1'b0;
      end
      @(posedge clk); #2;
      in_valid = 1'b1;
      in_sop = (i == 0);
      in_data = pkt[i];
      frame_len = 16'(flen);
      l2_len = 8'(l2);
      rcv_err = rcv;
      not_ip = nip;
      if (i == e_stop - 1) begin
        arm = 1;
        a_code = e_code; a_v6 = e_v6; a_frag = e_frag;
        a_l4 = e_l4; a_sec = e_sec; a_comp = e_comp; a_tag = tag;
      end
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #2;
      in_valid = 1'b0; in_sop = 1'b0;
    end
  endtask

  // per-clock comparison against the model
  initial begin
    forever begin
      @(posedge clk); #1;
      if (mon_on) begin
        chk(out_valid == arm, "R11", "out_valid", int'(out_valid), int'(arm));
        if (arm && out_valid) begin
          chk(exc_code == 8'(a_code), a_tag, "exc_code", int'(exc_code), a_code);
          chk(ip_exc == (a_code != 0), a_tag, "ip_exc", int'(ip_exc), int'(a_code != 0));
          chk(is_v6 == a_v6, a_tag, "is_v6", int'(is_v6), int'(a_v6));
          chk(is_frag == a_frag, a_tag, "is_frag", int'(is_frag), int'(a_frag));
          chk(is_l4tu == a_l4, a_tag, "is_l4tu", int'(is_l4tu), int'(a_l4));
          chk(is_ipsec == a_sec, a_tag, "is_ipsec", int'(is_ipsec), int'(a_sec));
          chk(is_comp == a_comp, a_tag, "is_comp", int'(is_comp), int'(a_comp));
        end
        arm = 0;
      end
    end
  end

  initial begin
    #(8 * 200000);
    n_chk++;
    n_fail++;
    $display("FAIL R11 watchdog actual=0 expected=1");
    summary();
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    #2 rst = 1'b0;
    @(posedge clk); #1;
    // R12 reset state
    chk(out_valid == 1'b0, "R12", "out_valid", int'(out_valid), 0);
    chk(ip_exc == 1'b0, "R12", "ip_exc", int'(ip_exc), 0);
    chk(exc_code == 8'd0, "R12", "exc_code", int'(exc_code), 0);
    mon_on = 1;

    // R8 protocol classes, exact-fit frames
    mk_v4(5, 20, 64, 6, 0, 1);    send(20, 34, 14, 0, 0, 0, "R8"); idle(2);
    mk_v4(5, 40, 64, 50, 0, 1);   send(20, 54, 14, 0, 0, 0, "R8"); idle(2);
    mk_v4(5, 40, 64, 51, 0, 1);   send(20, 54, 14, 0, 0, 0, "R8"); idle(2);
    mk_v4(5, 40, 64, 108, 0, 1);  send(20, 54, 14, 0, 0, 0, "R8"); idle(2);
    mk_v4(5, 40, 64, 1, 0, 1);    send(20, 54, 14, 0, 0, 0, "R8"); idle(2);
    // R4 pad bytes after the datagram are fine
    mk_v4(5, 40, 64, 17, 0, 1);   send(24, 74, 14, 0, 0, 0, "R4"); idle(2);
    // R9 fragments
    mk_v4(5, 20, 64, 6, 16'h2000, 1); send(20, 34, 14, 0, 0, 0, "R9"); idle(2);
    mk_v4(5, 20, 64, 6, 16'h0005, 1); send(20, 34, 14, 0, 0, 0, "R9"); idle(2);
    mk_v4(5, 20, 64, 6, 16'h4000, 1); send(20, 34, 14, 0, 0, 0, "R9"); idle(2);
    // R2 bad checksum
    mk_v4(5, 20, 64, 6, 0, 0);    send(20, 34, 14, 0, 0, 0, "R2"); idle(2);
    // R1 bad version, trailing bytes ignored
    mk_v4(5, 20, 64, 6, 0, 1); pkt[0] = 8'h55; send(20, 34, 14, 0, 0, 0, "R1"); idle(2);
    mk_v4(5, 20, 64, 6, 0, 1); pkt[0] = 8'h05; send(8, 34, 14, 0, 0, 0, "R1"); idle(2);
    // R3 truncated header and short header-length nibble
    mk_v4(5, 20, 64, 6, 0, 1);    send(20, 26, 14, 0, 0, 0, "R3"); idle(2);
    mk_v4(4, 20, 64, 6, 0, 1);    send(20, 60, 14, 0, 0, 0, "R3"); idle(2);
    mk_v4(5, 20, 64, 6, 0, 1);    send(4, 10, 14, 0, 0, 0, "R3"); idle(2);
    // R4 datagram longer than frame
    mk_v4(5, 100, 64, 6, 0, 1);   send(20, 74, 14, 0, 0, 0, "R4"); idle(2);
    // R5 zero TTL
    mk_v4(5, 20, 0, 6, 0, 1);     send(20, 34, 14, 0, 0, 0, "R5"); idle(2);
    // R6 options
    mk_v4(6, 24, 64, 17, 0, 1);   send(24, 38, 14, 0, 0, 0, "R6"); idle(2);
    mk_v4(15, 60, 64, 6, 0, 1);   send(60, 74, 14, 0, 0, 0, "R6"); idle(2);
    // R7 priority between overlapping causes
    mk_v4(5, 20, 0, 6, 0, 0);     send(20, 34, 14, 0, 0, 0, "R7"); idle(2);
    mk_v4(6, 200, 64, 6, 0, 1);   send(24, 38, 14, 0, 0, 0, "R7"); idle(2);
    mk_v4(6, 24, 0, 6, 0, 1);     send(24, 38, 14, 0, 0, 0, "R7"); idle(2);
    mk_v4(6, 24, 64, 6, 0, 1);    send(24, 30, 14, 0, 0, 0, "R7"); idle(2);
    // IPv6 cases
    mk_v6(20, 6, 64);             send(40, 74, 14, 0, 0, 0, "R8"); idle(2);
    mk_v6(20, 50, 64);            send(40, 74, 14, 0, 0, 0, "R8"); idle(2);
    mk_v6(20, 44, 64);            send(40, 74, 14, 0, 0, 0, "R9"); idle(2);
    mk_v6(20, 6, 0);              send(40, 74, 14, 0, 0, 0, "R5"); idle(2);
    mk_v6(100, 6, 64);            send(40, 74, 14, 0, 0, 0, "R4"); idle(2);
    mk_v6(20, 6, 64);             send(40, 44, 14, 0, 0, 0, "R3"); idle(2);
    // R10 suppression by upstream conditions
    mk_v4(5, 20, 0, 6, 0, 0);     send(20, 34, 14, 1, 0, 0, "R10"); idle(2);
    mk_v4(5, 20, 64, 6, 0, 1); pkt[0] = 8'h75; send(20, 34, 14, 0, 1, 0, "R10"); idle(2);
    mk_v6(20, 6, 64);             send(40, 74, 14, 0, 1, 0, "R10"); idle(2);
    // R11 idle gaps, then back-to-back packets
    mk_v4(6, 24, 64, 6, 16'h2000, 1); send(24, 38, 14, 0, 0, 1, "R11"); idle(2);
    mk_v6(20, 17, 64);            send(40, 74, 14, 0, 0, 1, "R11"); idle(2);
    mk_v4(5, 20, 64, 17, 0, 1);   send(20, 34, 14, 0, 0, 0, "R11");
    mk_v4(5, 20, 64, 6, 0, 0);    send(20, 34, 14, 0, 0, 0, "R11");
    pkt[0] = 8'h35;               send(1, 34, 14, 0, 0, 0, "R11");
    mk_v4(5, 20, 0, 50, 0, 1);    send(20, 34, 14, 0, 0, 0, "R11"); idle(4);

    summary();
    $finish;
  end

endmodule